// File: doc/BRIEF.md
# Serial Channel Flag Register with Read-Before-Clear

This block holds the status flags and the one-byte data holders of an asynchronous serial channel that has no FIFO. Software reaches it through a byte-wide register port with four locations: status, transmit byte, received byte and control. The serial line itself is replaced by a byte handshake: a one-cycle strobe delivers an incoming byte, and a one-cycle strobe presents an outgoing byte.

The status register carries four flags: transmitter empty, transmission finished, receive buffer full and receive overrun. The block tracks which flags software has seen set in a status read, and a status write can clear a flag only if it has been seen that way. A write of zero to a flag that software never saw set is ignored. When the transmitter is enabled and a status write clears the empty flag, the held transmit byte goes out on the next cycle and both transmit flags come back set.

Top module: `serial_flag_unit`

## Requirements
- R1: After reset the status register reads 0x84 (bit 7 transmitter empty, bit 2 transmission finished), the control register reads 0x00 and no transmit strobe is issued. Register addresses: 0 status, 1 transmit byte, 2 received byte, 3 control.
- R2: A status write leaves a flag in bits 7:3 set if no status read has seen that flag set since that flag's marker was last cleared, whatever value is written.
- R3: A flag in bits 7:3 that a status read has seen set is cleared by a status write with a 0 in that bit, and kept by a write with a 1 in that bit.
- R4: A status write never sets a bit in 7:3 that is clear. Bit 0 takes the written value, and bit 1 always reads 0.
- R5: Every status write ANDs the seen-marker with the written value, so a flag that is set again after such a clear cannot be cleared until another status read sees it.
- R6: While the transmit enable (control bit 5) is 0, every status write leaves bits 7 and 2 set and issues no transmit strobe.
- R7: While transmit enable is 1, a status write that clears the transmitter-empty flag produces exactly one transmit strobe on the next cycle, carrying the held transmit byte. Bits 7 and 2 read set again after it. A status write that does not clear the flag issues no strobe.
- R8: A write to the transmit byte register clears status bit 2 and leaves bit 7 unchanged.
- R9: A received-byte strobe with receive enable (control bit 4) at 1 and status bit 6 clear stores the byte and sets bit 6. A read of the received byte register returns the byte and clears bit 6.
- R10: A received-byte strobe while bit 6 is set discards the byte, keeps the stored byte and sets the overrun flag in bit 5.
- R11: A received-byte strobe while receive enable is 0 has no effect on the flags or the stored byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register access in this cycle |
| bus_we | input | 1 | 1 write, 0 read |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data of the addressed register during a read, else 0 |
| rx_valid | input | 1 | Incoming byte strobe |
| rx_byte | input | 8 | Incoming byte |
| tx_valid | output | 1 | One-cycle outgoing byte strobe |
| tx_byte | output | 8 | Outgoing byte, valid with tx_valid |

## Verification
The assertions take a register access and a received-byte strobe in the same cycle to be legal, with the access applied first and the arrival judged against the flag state it leaves. They also take it that only the status write path clears transmitter-empty. The stimulus still keeps register accesses and incoming strobes in separate cycles, so every expected value follows from one event at a time. It changes the enable bits only between operations.

// File: rtl/sfr_pkg.sv
package sfr_pkg;
    localparam int DW = 8;
    localparam int AW = 2;

    // status bit positions
    localparam int TXE_BIT    = 7;
    localparam int RXF_BIT    = 6;
    localparam int OVR_BIT    = 5;
    localparam int STICKY_LO  = 3;
    localparam int TEND_BIT   = 2;
    localparam int DIRECT_BIT = 0;

    // control bit positions
    localparam int TXEN_BIT = 5;
    localparam int RXEN_BIT = 4;

    localparam logic [DW-1:0] STAT_RST  = (DW'(1) << TXE_BIT) | (DW'(1) << TEND_BIT);
    localparam logic [DW-1:0] RULE_MASK = {DW{1'b1}} << STICKY_LO;

    typedef enum logic [AW-1:0] {
        REG_STAT = 2'd0,
        REG_TXD  = 2'd1,
        REG_RXD  = 2'd2,
        REG_CTRL = 2'd3
    } reg_id_e;

    typedef struct packed {
        logic stat_wr;
        logic stat_rd;
        logic txd_wr;
        logic rxd_rd;
        logic ctrl_wr;
    } bus_strobe_t;
endpackage

// File: rtl/sfr_bus_decode.sv
module sfr_bus_decode
    import sfr_pkg::*;
#(
    parameter int ADDR_W = AW
) (
    input  logic              sel,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    output bus_strobe_t       strb
);
    always_comb begin
        strb = '0;
        if (sel) begin
            unique case (reg_id_e'(addr))
                REG_STAT: begin
                    strb.stat_wr = we;
                    strb.stat_rd = !we;
                end
                REG_TXD:  strb.txd_wr  = we;
                REG_RXD:  strb.rxd_rd  = !we;
                REG_CTRL: strb.ctrl_wr = we;
                default:  strb = '0;
            endcase
        end
    end
endmodule

// File: rtl/sfr_rx_capture.sv
module sfr_rx_capture
    import sfr_pkg::*;
#(
    parameter int WIDTH = DW
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_valid,
    input  logic [WIDTH-1:0] rx_byte,
    input  logic             rx_en,
    input  logic             full_q,
    input  logic             rxd_rd,
    output logic             accept,
    output logic             overrun,
    output logic [WIDTH-1:0] hold_q
);
    logic [WIDTH-1:0] hold_d;
    logic             full_eff;

    always_comb begin
        // a read in the same cycle empties the holder before the arrival
        full_eff = full_q && !rxd_rd;
        accept   = rx_valid && rx_en && !full_eff;
        overrun  = rx_valid && rx_en && full_eff;
        hold_d   = accept ? rx_byte : hold_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) hold_q <= '0;
        else        hold_q <= hold_d;
    end
endmodule

// File: rtl/sfr_tx_hold.sv
module sfr_tx_hold
    import sfr_pkg::*;
#(
    parameter int WIDTH = DW
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [WIDTH-1:0] wdata,
    input  logic             send,
    output logic [WIDTH-1:0] hold_q,
    output logic             out_valid,
    output logic [WIDTH-1:0] out_byte
);
    typedef struct packed {
        logic [WIDTH-1:0] hold;
        logic             valid;
        logic [WIDTH-1:0] data;
    } tx_state_t;

    tx_state_t cur_q, nxt_d;

    always_comb begin
        nxt_d       = cur_q;
        nxt_d.valid = send;
        if (send) nxt_d.data = cur_q.hold;
        if (load) nxt_d.hold = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    assign hold_q    = cur_q.hold;
    assign out_valid = cur_q.valid;
    assign out_byte  = cur_q.data;
endmodule

// File: rtl/sfr_flag_core.sv
module sfr_flag_core
    import sfr_pkg::*;
#(
    parameter int WIDTH = DW
) (
    input  logic             clk,
    input  logic             rst_n,
    input  bus_strobe_t      strb,
    input  logic [WIDTH-1:0] wdata,
    input  logic             tx_en,
    input  logic             rx_accept,
    input  logic             rx_overrun,
    output logic [WIDTH-1:0] stat_q,
    output logic             send
);
    typedef struct packed {
        logic [WIDTH-1:0] stat;
        logic [WIDTH-1:0] seen;
    } flag_state_t;

    flag_state_t cur_q, nxt_d;
    logic [WIDTH-1:0] kept;

    always_comb begin
        nxt_d = cur_q;
        send  = 1'b0;
        kept  = cur_q.stat & (wdata | ~cur_q.seen);

        if (strb.stat_rd) nxt_d.seen = cur_q.seen | cur_q.stat;

        if (strb.stat_wr) begin
            nxt_d.stat             = kept & RULE_MASK;
            nxt_d.stat[TEND_BIT]   = cur_q.stat[TEND_BIT];
            nxt_d.stat[DIRECT_BIT] = wdata[DIRECT_BIT];
            nxt_d.seen             = cur_q.seen & wdata;
            if (!tx_en) begin
                nxt_d.stat[TXE_BIT]  = 1'b1;
                nxt_d.stat[TEND_BIT] = 1'b1;
            end else if (!nxt_d.stat[TXE_BIT]) begin
                // empty flag cleared: byte leaves, both flags return
                send                 = 1'b1;
                nxt_d.stat[TXE_BIT]  = 1'b1;
                nxt_d.stat[TEND_BIT] = 1'b1;
            end
        end

        if (strb.txd_wr) nxt_d.stat[TEND_BIT] = 1'b0;
        if (strb.rxd_rd) nxt_d.stat[RXF_BIT]  = 1'b0;
        if (rx_accept)   nxt_d.stat[RXF_BIT]  = 1'b1;
        if (rx_overrun)  nxt_d.stat[OVR_BIT]  = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q.stat <= STAT_RST;
            cur_q.seen <= '0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign stat_q = cur_q.stat;
endmodule

// File: rtl/serial_flag_unit.sv
module serial_flag_unit
    import sfr_pkg::*;
#(
    parameter int DATA_W = DW,
    parameter int ADDR_W = AW
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              rx_valid,
    input  logic [DATA_W-1:0] rx_byte,
    output logic              tx_valid,
    output logic [DATA_W-1:0] tx_byte
);
    bus_strobe_t       strb;
    logic [DATA_W-1:0] stat_q;
    logic [DATA_W-1:0] rx_hold_q;
    logic [DATA_W-1:0] tx_hold_q;
    logic [DATA_W-1:0] ctrl_q, ctrl_d;
    logic              rx_accept, rx_overrun, send;

    sfr_bus_decode #(.ADDR_W(ADDR_W)) u_dec (
        .sel  (bus_sel),
        .we   (bus_we),
        .addr (bus_addr),
        .strb (strb)
    );

    sfr_flag_core #(.WIDTH(DATA_W)) u_flags (
        .clk        (clk),
        .rst_n      (rst_n),
        .strb       (strb),
        .wdata      (bus_wdata),
        .tx_en      (ctrl_q[TXEN_BIT]),
        .rx_accept  (rx_accept),
        .rx_overrun (rx_overrun),
        .stat_q     (stat_q),
        .send       (send)
    );

    sfr_rx_capture #(.WIDTH(DATA_W)) u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .rx_valid (rx_valid),
        .rx_byte  (rx_byte),
        .rx_en    (ctrl_q[RXEN_BIT]),
        .full_q   (stat_q[RXF_BIT]),
        .rxd_rd   (strb.rxd_rd),
        .accept   (rx_accept),
        .overrun  (rx_overrun),
        .hold_q   (rx_hold_q)
    );

    sfr_tx_hold #(.WIDTH(DATA_W)) u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (strb.txd_wr),
        .wdata     (bus_wdata),
        .send      (send),
        .hold_q    (tx_hold_q),
        .out_valid (tx_valid),
        .out_byte  (tx_byte)
    );

    always_comb begin
        ctrl_d = strb.ctrl_wr ? bus_wdata : ctrl_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctrl_q <= '0;
        else        ctrl_q <= ctrl_d;
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_sel && !bus_we) begin
            unique case (reg_id_e'(bus_addr))
                REG_STAT: bus_rdata = stat_q;
                REG_TXD:  bus_rdata = tx_hold_q;
                REG_RXD:  bus_rdata = rx_hold_q;
                REG_CTRL: bus_rdata = ctrl_q;
                default:  bus_rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/serial_flag_unit_checker.sv
module serial_flag_unit_checker
    import sfr_pkg::*;
#(
    parameter int DATA_W = DW,
    parameter int ADDR_W = AW
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_sel,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              rx_valid,
    input logic              tx_valid,
    input logic [DATA_W-1:0] status,
    input logic [DATA_W-1:0] ctrl,
    input logic [DATA_W-1:0] rx_data
);
    logic stat_wr, txd_wr, rxd_rd, any_acc;
    assign any_acc = bus_sel;
    assign stat_wr = bus_sel && bus_we && (bus_addr == ADDR_W'(REG_STAT));
    assign txd_wr  = bus_sel && bus_we && (bus_addr == ADDR_W'(REG_TXD));
    assign rxd_rd  = bus_sel && !bus_we && (bus_addr == ADDR_W'(REG_RXD));

    assert_no_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_wr && status[4:3] == 2'b00) |=> status[4:3] == 2'b00);

    assert_tx_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |=> !tx_valid);

    assert_tx_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |-> ($past(stat_wr) && status[TXE_BIT] && status[TEND_BIT]));

    assert_tx_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_wr && !ctrl[TXEN_BIT]) |=> (!tx_valid && status[TXE_BIT] && status[TEND_BIT]));

    assert_tend_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        txd_wr |=> !status[TEND_BIT]);

    assert_rx_store_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && ctrl[RXEN_BIT] && !status[RXF_BIT]) |=> status[RXF_BIT]);

    assert_rx_overrun_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && ctrl[RXEN_BIT] && status[RXF_BIT] && !rxd_rd)
        |=> (status[OVR_BIT] && $stable(rx_data)));

    assert_rx_ignored_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && !ctrl[RXEN_BIT] && !any_acc && !status[RXF_BIT])
        |=> (!status[RXF_BIT] && $stable(rx_data)));
endmodule

bind serial_flag_unit serial_flag_unit_checker #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_sel  (bus_sel),
    .bus_we   (bus_we),
    .bus_addr (bus_addr),
    .rx_valid (rx_valid),
    .tx_valid (tx_valid),
    .status   (stat_q),
    .ctrl     (ctrl_q),
    .rx_data  (rx_hold_q)
);

// File: tb/serial_flag_unit_test.sv
module serial_flag_unit_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_sel = 1'b0, bus_we = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       rx_valid = 1'b0;
    logic [7:0] rx_byte = 8'h00;
    logic       tx_valid;
    logic [7:0] tx_byte;

    int checks = 0;
    int errors = 0;
    int tx_count = 0;
    logic [7:0] tx_last = 8'h00;

    always #5 clk = ~clk;

    serial_flag_unit uut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .rx_valid(rx_valid), .rx_byte(rx_byte), .tx_valid(tx_valid), .tx_byte(tx_byte)
    );

    always @(negedge clk) begin
        if (tx_valid) begin
            tx_count = tx_count + 1;
            tx_last  = tx_byte;
        end
    end

    // op 0 write, 1 read and compare, 2 received byte; fields {op,addr,data,expect,req}
    localparam int NV = 31;
    localparam logic [23:0] VEC [0:NV-1] = '{
        {2'd1, 2'd0, 8'h00, 8'h84, 4'd1},   // R1 status reset value
        {2'd1, 2'd3, 8'h00, 8'h00, 4'd1},   // R1 control reset value
        {2'd0, 2'd3, 8'h10, 8'h00, 4'd0},   // receive on, transmit off
        {2'd2, 2'd0, 8'h5A, 8'h00, 4'd0},
        {2'd1, 2'd0, 8'h00, 8'hC4, 4'd9},   // R9 full flag set
        {2'd1, 2'd2, 8'h00, 8'h5A, 4'd9},   // R9 byte read back
        {2'd1, 2'd0, 8'h00, 8'h84, 4'd9},   // R9 full flag cleared by read
        {2'd2, 2'd0, 8'h11, 8'h00, 4'd0},
        {2'd2, 2'd0, 8'h22, 8'h00, 4'd0},
        {2'd1, 2'd0, 8'h00, 8'hE4, 4'd10},  // R10 overrun flagged
        {2'd1, 2'd2, 8'h00, 8'h11, 4'd10},  // R10 second byte discarded
        {2'd0, 2'd0, 8'h00, 8'h00, 4'd0},
        {2'd1, 2'd0, 8'h00, 8'h84, 4'd6},   // R6 bits 7,2 forced; R3 overrun cleared
        {2'd0, 2'd3, 8'h00, 8'h00, 4'd0},
        {2'd2, 2'd0, 8'h77, 8'h00, 4'd0},
        {2'd1, 2'd0, 8'h00, 8'h84, 4'd11},  // R11 no flag change
        {2'd1, 2'd2, 8'h00, 8'h11, 4'd11},  // R11 byte not stored
        {2'd0, 2'd3, 8'h10, 8'h00, 4'd0},
        {2'd2, 2'd0, 8'h33, 8'h00, 4'd0},
        {2'd0, 2'd0, 8'h00, 8'h00, 4'd0},
        {2'd1, 2'd0, 8'h00, 8'hC4, 4'd2},   // R2 unseen full flag kept
        {2'd0, 2'd0, 8'hBF, 8'h00, 4'd0},
        {2'd1, 2'd0, 8'h00, 8'h85, 4'd3},   // R3 seen flag cleared; R4 bits 4:3 not set, bit 0 direct
        {2'd2, 2'd0, 8'h44, 8'h00, 4'd0},
        {2'd2, 2'd0, 8'h45, 8'h00, 4'd0},
        {2'd1, 2'd0, 8'h00, 8'hE5, 4'd10},  // R10 overrun again
        {2'd0, 2'd0, 8'hDF, 8'h00, 4'd0},
        {2'd2, 2'd0, 8'h46, 8'h00, 4'd0},
        {2'd0, 2'd0, 8'hDF, 8'h00, 4'd0},
        {2'd1, 2'd0, 8'h00, 8'hE5, 4'd5},   // R5 marker dropped: new overrun survives
        {2'd1, 2'd2, 8'h00, 8'h44, 4'd10}   // R10 first byte kept
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks = checks + 1;
        if (act !== exp) begin
            errors = errors + 1;
            $display("FAIL %s actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic check_int(input string req, input int act, input int exp);
        checks = checks + 1;
        if (act != exp) begin
            errors = errors + 1;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    task automatic bus_rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    task automatic rx_push(input logic [7:0] b);
        @(negedge clk);
        rx_valid = 1'b1; rx_byte = b;
        @(negedge clk);
        rx_valid = 1'b0;
    endtask

    initial begin
        #(200000 * 10);
        errors = errors + 1;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] rd;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_int("R1 tx strobe at reset", int'(tx_valid), 0);

        for (int i = 0; i < NV; i++) begin
            logic [1:0] op;
            op = VEC[i][23:22];
            if (op == 2'd0) bus_wr(VEC[i][21:20], VEC[i][19:12]);
            else if (op == 2'd2) rx_push(VEC[i][19:12]);
            else begin
                bus_rd(VEC[i][21:20], rd);
                check($sformatf("R%0d vector %0d", VEC[i][3:0], i), rd, VEC[i][11:4]);
            end
        end
        check_int("R6 no strobe while transmit off", tx_count, 0);

        // clear leftovers with transmit still off, then enable it
        bus_wr(2'd0, 8'h00);
        bus_wr(2'd3, 8'h30);
        bus_rd(2'd3, rd);
        check("R1 control readback", rd, 8'h30);

        bus_wr(2'd1, 8'hA5);
        bus_rd(2'd0, rd);
        check("R8 finished flag cleared by data write", rd, 8'h80);

        bus_wr(2'd0, 8'h7F);
        @(negedge clk);
        check_int("R7 one strobe", tx_count, 1);
        check("R7 strobe byte", tx_last, 8'hA5);
        bus_rd(2'd0, rd);
        check("R7 flags set after send", rd, 8'h85);

        bus_wr(2'd1, 8'h3C);
        bus_wr(2'd0, 8'hFF);
        @(negedge clk);
        check_int("R7 no strobe without clear", tx_count, 1);
        bus_rd(2'd0, rd);
        check("R8 empty flag kept by data write", rd, 8'h81);

        bus_wr(2'd0, 8'h7F);
        @(negedge clk);
        check_int("R7 second strobe", tx_count, 2);
        check("R7 second strobe byte", tx_last, 8'h3C);

        bus_wr(2'd0, 8'h7F);
        @(negedge clk);
        check_int("R2 unseen empty flag not cleared", tx_count, 2);
        bus_rd(2'd0, rd);
        check("R2 status after unseen clear", rd, 8'h85);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule